// File: doc/BRIEF.md
# Copy Request Burst Fragmenter

This block turns one memory-copy request into a series of bus burst commands. A request gives a source address, a destination address and a length in bytes. The block reads the source in pieces no larger than the read burst limit and writes the destination in pieces no larger than the write burst limit. The two limits are set independently and can differ. Two more settings, one per direction, bound how many commands may be in flight at once.

Each burst command leaves on a valid/ready channel. Valid is raised when a command is eligible. The address and byte count then stay fixed until ready is seen high at a clock edge. The consumer may hold ready low for as long as it needs. Completions come back as one-cycle pulses on a plain strobe, one per earlier command of that direction and in issue order. They are always accepted.

A write piece is released only when the read completions received so far cover every byte it carries. A one-cycle done pulse marks the last write completion of the request. The request channel takes a new request only while no copy is in progress.

Top module: `copy_splitter`

## Requirements
- R1: `req_ready` is high exactly when no copy is in progress. A request is taken on a clock edge with `req_valid` and `req_ready` both high, and `req_ready` is low from the next cycle until the copy finishes.
- R2: Read commands start at the source address and cover the request without gaps. Each one carries the read burst limit in bytes, except that the last carries the remaining count when the length is not a multiple of the limit. Both limits are captured when the request is taken.
- R3: Write commands follow the same rule from the destination address, using the write burst limit.
- R4: The burst configuration word is written with `cfg_burst_we`. Bits 31:16 hold the write limit and bits 15:0 the read limit, both in bytes. A field is accepted only if it is 128, 256, 512 or 1024. Any other value leaves that field unchanged and sets the sticky `cfg_err` flag, which only reset clears. A legal field in the same word is still applied.
- R5: The cap word is written with `cfg_cap_we`. Bits 4:0 hold the read cap. The number of read commands issued but not yet completed never exceeds this cap. A new read command is withheld while the count equals the cap.
- R6: Bits 20:16 of the cap word hold the write cap, which bounds outstanding write commands in the same way.
- R7: A write command is issued only if its last byte lies within the bytes whose read completions have already arrived.
- R8: `done` pulses high for exactly one cycle after the completion of the request's final write. A zero-length request issues no command and gives its `done` pulse two cycles after it is taken.
- R9: While a command waits with valid high and ready low, its address and byte count stay unchanged. Valid drops before acceptance only if its cap is lowered.
- R10: After reset both burst limits are 256 bytes, both caps are 4, `cfg_err` is low, `req_ready` is high, and neither command valid nor `done` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_we | input | 1 | Write strobe for the burst limit word |
| cfg_burst_word | input | 32 | Write limit [31:16], read limit [15:0] |
| cfg_cap_we | input | 1 | Write strobe for the cap word |
| cfg_cap_word | input | 32 | Write cap [20:16], read cap [4:0] |
| cfg_err | output | 1 | Sticky flag for a rejected burst limit |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Copy request accepted when high with valid |
| req_src | input | AW | Source start address |
| req_dst | input | AW | Destination start address |
| req_len | input | LW | Length in bytes |
| rd_cmd_valid | output | 1 | Read burst command present |
| rd_cmd_ready | input | 1 | Read command consumed |
| rd_cmd_addr | output | AW | Read burst address |
| rd_cmd_bytes | output | 11 | Read burst size in bytes |
| rd_cpl_valid | input | 1 | One read burst completed |
| wr_cmd_valid | output | 1 | Write burst command present |
| wr_cmd_ready | input | 1 | Write command consumed |
| wr_cmd_addr | output | AW | Write burst address |
| wr_cmd_bytes | output | 11 | Write burst size in bytes |
| wr_cpl_valid | input | 1 | One write burst completed |
| done | output | 1 | One-cycle pulse when the copy is finished |

## Verification
The splitting is tried with lengths that are exact multiples of both limits, lengths with a remainder, and a length below one burst. It is also tried with a write limit both smaller and larger than the read limit. These patterns separate the full-size pieces from the tail piece, and they show whether the write-after-read gate tracks completed bytes rather than command counts. Caps of 1 are paired with slow completions, and a cap of 31 with fast ones, so that a miscounted outstanding counter shows up as an excess or a stall. Ready is toggled throughout so that held commands are observed. Illegal limits are applied in each field separately, and a zero-length request checks the completion path.

// File: rtl/copy_split_pkg.sv
package copy_split_pkg;
  localparam int unsigned BURST_MIN = 128;
  localparam int unsigned BURST_MAX = 1024;
  localparam int unsigned BW = $clog2(BURST_MAX) + 1;  // byte-count width
  localparam int unsigned CW = 5;                      // cap field width
  localparam int unsigned NDIR = 2;                    // 0 = read, 1 = write

  function automatic logic burst_ok(input logic [15:0] v);
    return ($countones(v) == 1) && (v >= 16'(BURST_MIN)) && (v <= 16'(BURST_MAX));
  endfunction
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import copy_split_pkg::*;
#(
  parameter int unsigned RST_BURST = 256,
  parameter int unsigned RST_CAP   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     burst_we,
  input  logic [31:0]              burst_word,
  input  logic                     cap_we,
  input  logic [31:0]              cap_word,
  output logic [NDIR-1:0][BW-1:0]  burst,
  output logic [NDIR-1:0][CW-1:0]  cap,
  output logic                     err
);
  logic [NDIR-1:0] bad;
  logic unused_bits;
  assign unused_bits = ^{cap_word[31:16+CW], cap_word[15:CW]};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    logic [15:0]   fld;
    logic [BW-1:0] bs_r;
    logic [CW-1:0] cap_r;
    assign fld      = burst_word[16*g +: 16];
    assign bad[g]   = burst_we && !burst_ok(fld);
    assign burst[g] = bs_r;
    assign cap[g]   = cap_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bs_r  <= BW'(RST_BURST);
        cap_r <= CW'(RST_CAP);
      end else begin
        if (burst_we && burst_ok(fld)) bs_r <= fld[BW-1:0];
        if (cap_we) cap_r <= cap_word[16*g +: CW];
      end
    end

    // R4: the held limit is always one of the legal sizes
    a_r4_legal_limit: assert property (@(posedge clk) disable iff (!rst_n)
      burst_ok(16'(bs_r)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else if (|bad) err <= 1'b1;
  end

  // R4: the error flag never clears outside reset
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/cs_lane.sv
module cs_lane
  import copy_split_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic [BW-1:0] bs,
  input  logic [CW-1:0] cap,
  input  logic [LW-1:0] gate,
  input  logic          cmd_ready,
  input  logic          cpl_valid,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [BW-1:0] cmd_bytes,
  output logic [LW-1:0] issued,
  output logic [LW-1:0] cpl,
  output logic          fin
);
  logic [AW-1:0] base_q;
  logic [LW-1:0] len_q, off_q, cpl_q;
  logic [BW-1:0] bs_q;
  logic [CW-1:0] outst_q;
  logic [LW-1:0] rem_iss, rem_cpl, cpl_inc;
  logic [LW:0]   end_off;
  logic          fire;

  always_comb begin
    rem_iss   = len_q - off_q;
    cmd_bytes = (rem_iss < LW'(bs_q)) ? rem_iss[BW-1:0] : bs_q;
    end_off   = {1'b0, off_q} + (LW+1)'(cmd_bytes);
    cmd_valid = run && (off_q != len_q) && (outst_q < cap) && (end_off <= {1'b0, gate});
    cmd_addr  = base_q + AW'(off_q);
    rem_cpl   = len_q - cpl_q;
    cpl_inc   = (rem_cpl < LW'(bs_q)) ? rem_cpl : LW'(bs_q);
    fire      = cmd_valid && cmd_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      bs_q    <= BW'(BURST_MAX);
      off_q   <= '0;
      cpl_q   <= '0;
      outst_q <= '0;
    end else begin
      if (start) begin
        base_q <= base;
        len_q  <= len;
        bs_q   <= bs;
        off_q  <= '0;
        cpl_q  <= '0;
      end else begin
        if (fire)      off_q <= end_off[LW-1:0];
        if (cpl_valid) cpl_q <= cpl_q + cpl_inc;
      end
      case ({fire, cpl_valid})
        2'b10:   outst_q <= outst_q + 1'b1;
        2'b01:   outst_q <= outst_q - 1'b1;
        default: outst_q <= outst_q;
      endcase
    end
  end

  assign issued = off_q;
  assign cpl    = cpl_q;
  assign fin    = (cpl_q == len_q);

  // R9: a waiting command keeps its fields
  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (!cmd_valid || ($stable(cmd_addr) && $stable(cmd_bytes))));
  // R2 / R3: every command is non-empty and within the captured limit
  a_r2_size_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_bytes != '0) && (cmd_bytes <= bs_q));
endmodule

// File: rtl/copy_splitter.sv
module copy_splitter
  import copy_split_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 16,
  parameter int unsigned RST_BURST = 256,
  parameter int unsigned RST_CAP   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_burst_we,
  input  logic [31:0]   cfg_burst_word,
  input  logic          cfg_cap_we,
  input  logic [31:0]   cfg_cap_word,
  output logic          cfg_err,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_src,
  input  logic [AW-1:0] req_dst,
  input  logic [LW-1:0] req_len,
  output logic          rd_cmd_valid,
  input  logic          rd_cmd_ready,
  output logic [AW-1:0] rd_cmd_addr,
  output logic [BW-1:0] rd_cmd_bytes,
  input  logic          rd_cpl_valid,
  output logic          wr_cmd_valid,
  input  logic          wr_cmd_ready,
  output logic [AW-1:0] wr_cmd_addr,
  output logic [BW-1:0] wr_cmd_bytes,
  input  logic          wr_cpl_valid,
  output logic          done
);
  logic [NDIR-1:0][BW-1:0] burst;
  logic [NDIR-1:0][CW-1:0] cap;
  logic busy_q, done_q, accept;
  logic [LW-1:0] rd_issued, rd_cpl, wr_issued, wr_cpl;
  logic rd_fin, wr_fin;

  cs_cfg_regs #(.RST_BURST(RST_BURST), .RST_CAP(RST_CAP)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .burst_we(cfg_burst_we), .burst_word(cfg_burst_word),
    .cap_we(cfg_cap_we), .cap_word(cfg_cap_word),
    .burst(burst), .cap(cap), .err(cfg_err)
  );

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;

  cs_lane #(.AW(AW), .LW(LW)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy_q),
    .base(req_src), .len(req_len), .bs(burst[0]), .cap(cap[0]),
    .gate({LW{1'b1}}), .cmd_ready(rd_cmd_ready), .cpl_valid(rd_cpl_valid),
    .cmd_valid(rd_cmd_valid), .cmd_addr(rd_cmd_addr), .cmd_bytes(rd_cmd_bytes),
    .issued(rd_issued), .cpl(rd_cpl), .fin(rd_fin)
  );

  cs_lane #(.AW(AW), .LW(LW)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy_q),
    .base(req_dst), .len(req_len), .bs(burst[1]), .cap(cap[1]),
    .gate(rd_cpl), .cmd_ready(wr_cmd_ready), .cpl_valid(wr_cpl_valid),
    .cmd_valid(wr_cmd_valid), .cmd_addr(wr_cmd_addr), .cmd_bytes(wr_cmd_bytes),
    .issued(wr_issued), .cpl(wr_cpl), .fin(wr_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && wr_fin;
      if (accept) busy_q <= 1'b1;
      else if (busy_q && wr_fin) busy_q <= 1'b0;
    end
  end

  assign done = done_q;

  logic unused_lane;
  assign unused_lane = ^{rd_issued, wr_cpl, rd_fin};

  // R7: written bytes never run ahead of completed reads
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issued <= rd_cpl);
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: no request is taken while a copy runs
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sim_copy_splitter.sv
module sim_copy_splitter;
  import copy_split_pkg::*;
  localparam int unsigned AW = 32;
  localparam int unsigned LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_burst_we = 1'b0, cfg_cap_we = 1'b0;
  logic [31:0] cfg_burst_word = '0, cfg_cap_word = '0;
  logic cfg_err;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_src = '0, req_dst = '0;
  logic [LW-1:0] req_len = '0;
  logic rd_cmd_valid, rd_cmd_ready = 1'b0, rd_cpl_valid = 1'b0;
  logic wr_cmd_valid, wr_cmd_ready = 1'b0, wr_cpl_valid = 1'b0;
  logic [AW-1:0] rd_cmd_addr, wr_cmd_addr;
  logic [BW-1:0] rd_cmd_bytes, wr_cmd_bytes;
  logic done;

  always #5 clk = ~clk;

  copy_splitter u0 (.*);

  int checks = 0, fails = 0;
  int cyc = 0;
  // per-run bookkeeping, maintained by the bus model below
  int e_len, e_rbs, e_wbs, e_rcap, e_wcap, e_dly;
  int unsigned e_src, e_dst;
  int rd_n, wr_n, rd_iss, wr_iss, rd_cb, wr_cb, rd_pend, wr_pend;
  int rd_max, wr_max, addr_err, order_err, hold_err, done_n;
  bit rd_wait, wr_wait;
  logic [AW-1:0] rd_w_addr, wr_w_addr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic clear_run();
    rd_n = 0; wr_n = 0; rd_iss = 0; wr_iss = 0; rd_cb = 0; wr_cb = 0;
    rd_pend = 0; wr_pend = 0; rd_max = 0; wr_max = 0;
    addr_err = 0; order_err = 0; hold_err = 0; done_n = 0;
    rd_wait = 0; wr_wait = 0;
  endtask

  // bus model: readies, completions and observation, all at the falling edge
  initial begin
    e_dly = 1; e_len = 0; e_rbs = 256; e_wbs = 256;
    clear_run();
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        int rd_add, wr_add;
        rd_add = 0; wr_add = 0;
        rd_cpl_valid = (rd_pend > 0) && (cyc % e_dly == 0);
        wr_cpl_valid = (wr_pend > 0) && ((cyc + 1) % e_dly == 0);
        if (rd_cpl_valid) begin rd_pend--; rd_add = min2(e_rbs, e_len - rd_cb); end
        if (wr_cpl_valid) begin wr_pend--; wr_add = min2(e_wbs, e_len - wr_cb); end
        rd_cmd_ready = (cyc % 3) != 0;
        wr_cmd_ready = (cyc % 4) != 1;
        #1;
        if (rd_wait && rd_cmd_valid && rd_cmd_addr != rd_w_addr) hold_err++;
        if (wr_wait && wr_cmd_valid && wr_cmd_addr != wr_w_addr) hold_err++;
        rd_wait = rd_cmd_valid && !rd_cmd_ready; rd_w_addr = rd_cmd_addr;
        wr_wait = wr_cmd_valid && !wr_cmd_ready; wr_w_addr = wr_cmd_addr;
        if (rd_cmd_valid && rd_cmd_ready) begin
          int eb;
          eb = min2(e_rbs, e_len - rd_iss);
          if (rd_cmd_addr != AW'(e_src + rd_iss) || int'(rd_cmd_bytes) != eb) addr_err++;
          rd_iss += eb; rd_n++; rd_pend++;
          if (rd_pend > rd_max) rd_max = rd_pend;
        end
        if (wr_cmd_valid && wr_cmd_ready) begin
          int eb;
          eb = min2(e_wbs, e_len - wr_iss);
          if (wr_cmd_addr != AW'(e_dst + wr_iss) || int'(wr_cmd_bytes) != eb) addr_err++;
          if (wr_iss + eb > rd_cb) order_err++;
          wr_iss += eb; wr_n++; wr_pend++;
          if (wr_pend > wr_max) wr_max = wr_pend;
        end
        rd_cb += rd_add; wr_cb += wr_add;
        if (done) done_n++;
      end
    end
  end

  task automatic write_cfg(input int rbs, input int wbs, input int rcap, input int wcap);
    @(negedge clk);
    cfg_burst_word = {16'(wbs), 16'(rbs)};
    cfg_cap_word   = {11'd0, 5'(wcap), 11'd0, 5'(rcap)};
    cfg_burst_we = 1'b1; cfg_cap_we = 1'b1;
    @(negedge clk);
    cfg_burst_we = 1'b0; cfg_cap_we = 1'b0;
  endtask

  // issue one request and check its outcome against expectations
  task automatic run(input string tag, input int len, input int rbs, input int wbs,
                     input int rcap, input int wcap, input int dly, input int unsigned src,
                     input int unsigned dst, input bit check_busy);
    int waited;
    @(negedge clk);
    e_len = len; e_rbs = rbs; e_wbs = wbs; e_rcap = rcap; e_wcap = wcap; e_dly = dly;
    e_src = src; e_dst = dst;
    clear_run();
    req_src = src; req_dst = dst; req_len = LW'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    if (check_busy) chk(req_ready == 1'b0, {tag, " R1 ready low while busy"}, req_ready, 0);
    waited = 0;
    while (done_n == 0 && waited < 20000) begin @(negedge clk); waited++; end
    repeat (4) @(negedge clk);
    chk(rd_n == (len + rbs - 1) / rbs, {tag, " R2 read command count"}, rd_n, (len + rbs - 1) / rbs);
    chk(wr_n == (len + wbs - 1) / wbs, {tag, " R3 write command count"}, wr_n, (len + wbs - 1) / wbs);
    chk(addr_err == 0, {tag, " R2/R3 address and size"}, addr_err, 0);
    chk(rd_max <= rcap, {tag, " R5 read outstanding"}, rd_max, rcap);
    chk(wr_max <= wcap, {tag, " R6 write outstanding"}, wr_max, wcap);
    chk(order_err == 0, {tag, " R7 write after read"}, order_err, 0);
    chk(hold_err == 0, {tag, " R9 held command"}, hold_err, 0);
    chk(done_n == 1, {tag, " R8 single done"}, done_n, 1);
    chk(req_ready == 1'b1, {tag, " R1 ready after done"}, req_ready, 1);
  endtask

  // len, read limit, write limit, read cap, write cap, completion spacing
  localparam int VEC [5][6] = '{
    '{1024,  256,  128,  4,  4, 1},
    '{1000,  512,  256,  2,  3, 2},
    '{ 100, 1024,  128,  1,  1, 1},
    '{2048,  128, 1024,  1, 31, 3},
    '{ 777,  128,  512, 31,  2, 4}
  };

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R10: reset state
    chk(req_ready == 1'b1, "R10 req_ready at reset", req_ready, 1);
    chk(rd_cmd_valid == 1'b0 && wr_cmd_valid == 1'b0, "R10 no command at reset", rd_cmd_valid, 0);
    chk(done == 1'b0, "R10 done low at reset", done, 0);
    chk(cfg_err == 1'b0, "R10 error low at reset", cfg_err, 0);
    rst_n = 1'b1;
    // R10: default limits 256/256 and caps 4/4
    run("default", 600, 256, 256, 4, 4, 2, 32'h0000_4000, 32'h0008_0000, 1'b1);

    for (int i = 0; i < 5; i++) begin
      write_cfg(VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      run($sformatf("vec%0d", i), VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
          VEC[i][5], 32'h1000_0000 + 32'(i) * 32'h1_0000, 32'h2000_0000 + 32'(i) * 32'h1_0000, 1'b1);
    end
    chk(cfg_err == 1'b0, "R4 no error after legal writes", cfg_err, 0);

    // R4: illegal write field keeps 512, legal read field 128 is applied
    @(negedge clk);
    cfg_burst_word = {16'd300, 16'd128}; cfg_burst_we = 1'b1;
    @(negedge clk);
    cfg_burst_we = 1'b0;
    #2;
    chk(cfg_err == 1'b1, "R4 error set on bad write limit", cfg_err, 1);
    run("r4_wr_bad", 1100, 128, 512, 31, 2, 1, 32'h3000_0000, 32'h3800_0000, 1'b0);

    // R4: illegal read field keeps 128, write field 256 is applied, flag stays set
    @(negedge clk);
    cfg_burst_word = {16'd256, 16'd96}; cfg_burst_we = 1'b1;
    @(negedge clk);
    cfg_burst_we = 1'b0;
    run("r4_rd_bad", 600, 128, 256, 31, 2, 2, 32'h4000_0000, 32'h4800_0000, 1'b0);
    chk(cfg_err == 1'b1, "R4 error remains sticky", cfg_err, 1);

    // R8: zero-length request, done two cycles after acceptance, no commands
    @(negedge clk);
    clear_run(); e_len = 0;
    req_len = '0; req_valid = 1'b1;
    @(negedge clk);  // accepted at the preceding rising edge
    req_valid = 1'b0;
    #2;
    chk(done == 1'b0, "R8 zero length no done yet", done, 0);
    @(negedge clk);
    #2;
    chk(done == 1'b1, "R8 zero length done pulse", done, 1);
    @(negedge clk);
    #2;
    chk(done == 1'b0, "R8 zero length pulse ends", done, 0);
    chk(rd_n == 0 && wr_n == 0, "R8 zero length no commands", rd_n + wr_n, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule